// File: doc/BRIEF.md
# Adaptive Supply Ratio Controller

This block selects the conversion ratio of a switched-capacitor DC-DC converter that feeds a bipolar current stimulator, so that the stimulator supply stays only slightly above what the present current and load need. A lower supply means less voltage is lost across the current source. The block also generates the two non-overlapping switch phases for the converter, one pair for the positive supply and one pair for the negative supply. Only the pair that matches the sign of the stimulation current toggles.

An evaluation window is opened by holding `eval_en` high. When the window opens, the block latches the current sign and predicts a starting ratio from the top bits of the amplitude magnitude. An external comparator reports through `hdr_low` whether the supply margin is too small. The block samples that flag once every few switching periods and raises the ratio one step each time the margin is short, stopping at the highest supply. When `eval_en` falls, the chosen ratio and polarity are frozen until the next window opens.

Top module: `supply_ratio_ctrl`

## Requirements
- R1: While `rst_n` is low, `ratio_code` is 4, `pol_neg` is 0 and all four phase outputs are low. These values hold on the first cycle after reset.
- R2: The active phase pair repeats with a period of 2*PH_LEN+2 fast clock cycles. P1 is high for PH_LEN cycles, then low for one dead cycle. P2 is then high for PH_LEN cycles, then low for one dead cycle. The period counter runs freely from reset.
- R3: P1 and P2 of the same rail are never high in the same cycle.
- R4: When `pol_neg` is 0 only `p1_pos`/`p2_pos` toggle and the negative pair stays low. When `pol_neg` is 1 the opposite holds.
- R5: On the clock edge where `eval_en` is first seen high after being low, `pol_neg` takes the value of `amp_neg`. The value 1 selects the negative rail. At all other times `pol_neg` holds.
- R6: On that same edge, `ratio_code` loads the top three bits of `amp_mag` (bits 7:5), clamped to 4. The code meanings are: 0 selects 5:1 (lowest supply), 1 selects 3:1, 2 selects 2:1, 3 selects 3:2, and 4 selects 6:5 (highest supply).
- R7: While evaluation is open, a settle counter is cleared at the start and advances at the end of each switching period. At the end of every SETTLE_CYC-th period, if `hdr_low` is 1, `ratio_code` rises by exactly one.
- R8: `ratio_code` never exceeds 4. Predictions of 5 to 7 load 4, and a step request at code 4 leaves the code at 4.
- R9: While `eval_en` is low, `ratio_code` and `pol_neg` do not change, whatever `hdr_low`, `amp_mag` and `amp_neg` do.
- R10: If `hdr_low` is 0 at the end of a settle interval, the code stays where it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock for the controller and the phase generator |
| rst_n | input | 1 | Synchronous active-low reset |
| amp_mag | input | AMP_W | Stimulation amplitude magnitude |
| amp_neg | input | 1 | Stimulation current sign, 1 = negative |
| eval_en | input | 1 | Evaluation window; opens on a rise, freezes on a fall |
| hdr_low | input | 1 | Comparator flag, 1 = insufficient supply margin |
| ratio_code | output | CODE_W | Selected conversion ratio code, 0 to 4 |
| pol_neg | output | 1 | Selected supply rail, 1 = negative |
| p1_pos | output | 1 | Phase 1 for the positive-supply converter |
| p2_pos | output | 1 | Phase 2 for the positive-supply converter |
| p1_neg | output | 1 | Phase 1 for the negative-supply converter |
| p2_neg | output | 1 | Phase 2 for the negative-supply converter |

## Verification
A wrong period-counter value shifts the phase edges, so it is visible at the phase pins within one fast clock cycle. A bad settle counter or a wrong step decision is only seen when `ratio_code` moves at the wrong period boundary. That can take up to SETTLE_CYC switching periods, so the bench holds each evaluation window open for several settle intervals. A polarity latched at the wrong moment shows up at once, because the wrong phase pair starts toggling.

// File: rtl/sr_pkg.sv
package sr_pkg;
   // Clamp a candidate code to the highest legal ratio code
   function automatic int unsigned sr_clamp(input int unsigned val, input int unsigned max_code);
      return (val > max_code) ? max_code : val;
   endfunction
endpackage

// File: rtl/sr_phase_gen.sv
module sr_phase_gen #(
   parameter int PH_LEN = 24
) (
   input  logic clk,
   input  logic rst_n,
   output logic ph1,
   output logic ph2,
   output logic period_end
);
   localparam int PERIOD = 2 * PH_LEN + 2;
   localparam int CNT_W  = $clog2(PERIOD);
   localparam logic [CNT_W-1:0] LAST   = CNT_W'(PERIOD - 1);
   localparam logic [CNT_W-1:0] P2_BEG = CNT_W'(PH_LEN + 1);
   localparam logic [CNT_W-1:0] P2_END = CNT_W'(2 * PH_LEN);
   localparam logic [CNT_W-1:0] P1_END = CNT_W'(PH_LEN);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)             cnt_q <= '0;
      else if (cnt_q == LAST) cnt_q <= '0;
      else                    cnt_q <= cnt_q + CNT_W'(1);
   end

   assign ph1        = (cnt_q < P1_END);
   assign ph2        = (cnt_q >= P2_BEG) && (cnt_q <= P2_END);
   assign period_end = (cnt_q == LAST);
endmodule

// File: rtl/sr_ratio_search.sv
module sr_ratio_search
   import sr_pkg::*;
#(
   parameter int AMP_W      = 8,
   parameter int CODE_W     = 3,
   parameter int NUM_RATIOS = 5,
   parameter int SETTLE_CYC = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              eval_en,
   input  logic [AMP_W-1:0]  amp_mag,
   input  logic              amp_neg,
   input  logic              hdr_low,
   input  logic              period_end,
   output logic [CODE_W-1:0] code,
   output logic              pol_neg
);
   localparam int SET_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
   localparam logic [CODE_W-1:0] MAX_CODE = CODE_W'(NUM_RATIOS - 1);
   localparam logic [SET_W-1:0]  SET_LAST = SET_W'(SETTLE_CYC - 1);

   logic             en_prev_q;
   logic             start;
   logic [SET_W-1:0] settle_q;
   logic [CODE_W-1:0] predicted;

   // previous-enable register follows the input even in reset
   always_ff @(posedge clk) en_prev_q <= eval_en;

   assign start     = eval_en & ~en_prev_q;
   assign predicted = CODE_W'(sr_clamp(int'(amp_mag[AMP_W-1 -: CODE_W]), int'(MAX_CODE)));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         code     <= MAX_CODE;
         pol_neg  <= 1'b0;
         settle_q <= '0;
      end else if (start) begin
         code     <= predicted;
         pol_neg  <= amp_neg;
         settle_q <= '0;
      end else if (eval_en && period_end) begin
         if (settle_q == SET_LAST) begin
            settle_q <= '0;
            if (hdr_low && (code < MAX_CODE)) code <= code + CODE_W'(1);
         end else begin
            settle_q <= settle_q + SET_W'(1);
         end
      end
   end
endmodule

// File: rtl/supply_ratio_ctrl.sv
module supply_ratio_ctrl #(
   parameter int AMP_W      = 8,
   parameter int CODE_W     = 3,
   parameter int NUM_RATIOS = 5,
   parameter int SETTLE_CYC = 4,
   parameter int PH_LEN     = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [AMP_W-1:0]  amp_mag,
   input  logic              amp_neg,
   input  logic              eval_en,
   input  logic              hdr_low,
   output logic [CODE_W-1:0] ratio_code,
   output logic              pol_neg,
   output logic              p1_pos,
   output logic              p2_pos,
   output logic              p1_neg,
   output logic              p2_neg
);
   initial begin
      assert (PH_LEN >= 1) else $error("PH_LEN must be at least 1");
      assert (SETTLE_CYC >= 1) else $error("SETTLE_CYC must be at least 1");
      assert (NUM_RATIOS >= 2 && NUM_RATIOS <= (1 << CODE_W)) else $error("NUM_RATIOS does not fit CODE_W");
      assert (AMP_W >= CODE_W) else $error("AMP_W narrower than CODE_W");
   end

   logic ph1, ph2, period_end;
   logic [1:0] rail_p1, rail_p2;

   sr_phase_gen #(.PH_LEN(PH_LEN)) u_phase (
      .clk(clk), .rst_n(rst_n), .ph1(ph1), .ph2(ph2), .period_end(period_end)
   );

   sr_ratio_search #(
      .AMP_W(AMP_W), .CODE_W(CODE_W), .NUM_RATIOS(NUM_RATIOS), .SETTLE_CYC(SETTLE_CYC)
   ) u_search (
      .clk(clk), .rst_n(rst_n), .eval_en(eval_en), .amp_mag(amp_mag), .amp_neg(amp_neg),
      .hdr_low(hdr_low), .period_end(period_end), .code(ratio_code), .pol_neg(pol_neg)
   );

   // rail 0 = positive supply, rail 1 = negative supply
   for (genvar r = 0; r < 2; r++) begin : g_rail
      assign rail_p1[r] = rst_n & ph1 & (pol_neg == 1'(r));
      assign rail_p2[r] = rst_n & ph2 & (pol_neg == 1'(r));
   end

   assign p1_pos = rail_p1[0];
   assign p2_pos = rail_p2[0];
   assign p1_neg = rail_p1[1];
   assign p2_neg = rail_p2[1];
endmodule

// File: rtl/sr_checker.sv
module sr_checker #(
   parameter int CODE_W     = 3,
   parameter int NUM_RATIOS = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              eval_en,
   input logic [CODE_W-1:0] ratio_code,
   input logic              pol_neg,
   input logic              p1_pos,
   input logic              p2_pos,
   input logic              p1_neg,
   input logic              p2_neg
);
   localparam logic [CODE_W-1:0] MAX_CODE = CODE_W'(NUM_RATIOS - 1);

   AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(p1_pos && p2_pos) && !(p1_neg && p2_neg)); // R3
   AST_RAIL_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      pol_neg ? !(p1_pos || p2_pos) : !(p1_neg || p2_neg)); // R4
   AST_POL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(eval_en) |=> $stable(pol_neg)); // R5
   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(eval_en) |=> (ratio_code == $past(ratio_code)) || (ratio_code == $past(ratio_code) + CODE_W'(1))); // R7
   AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      ratio_code <= MAX_CODE); // R8
   AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !eval_en |=> $stable(ratio_code)); // R9
endmodule

bind supply_ratio_ctrl sr_checker #(.CODE_W(CODE_W), .NUM_RATIOS(NUM_RATIOS)) u_sr_chk (
   .clk(clk), .rst_n(rst_n), .eval_en(eval_en), .ratio_code(ratio_code), .pol_neg(pol_neg),
   .p1_pos(p1_pos), .p2_pos(p2_pos), .p1_neg(p1_neg), .p2_neg(p2_neg)
);

// File: tb/test_supply_ratio_ctrl.sv
module test_supply_ratio_ctrl;
   localparam int PH_LEN = 24;
   localparam int PERIOD = 2 * PH_LEN + 2;
   localparam int SETTLE = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [7:0] amp_mag = '0;
   logic amp_neg = 1'b0, eval_en = 1'b0, hdr_low = 1'b0;
   logic [2:0] ratio_code;
   logic pol_neg, p1_pos, p2_pos, p1_neg, p2_neg;

   int n_tests = 0, n_fail = 0;
   bit done = 0;

   // reference model state
   int m_pcnt = 0, m_code = 4, m_settle = 0, m_pol = 0, m_prev = 0;

   always #5 clk = ~clk;

   supply_ratio_ctrl #(.PH_LEN(PH_LEN), .SETTLE_CYC(SETTLE)) i_supply_ratio_ctrl (
      .clk(clk), .rst_n(rst_n), .amp_mag(amp_mag), .amp_neg(amp_neg), .eval_en(eval_en),
      .hdr_low(hdr_low), .ratio_code(ratio_code), .pol_neg(pol_neg),
      .p1_pos(p1_pos), .p2_pos(p2_pos), .p1_neg(p1_neg), .p2_neg(p2_neg)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // behavioural reference, updated on every rising edge
   always @(posedge clk) begin
      int start, pend, upper;
      start = eval_en && !m_prev;
      pend  = (m_pcnt == PERIOD - 1);
      upper = amp_mag >> 5;
      if (!rst_n) begin
         m_code = 4; m_pol = 0; m_settle = 0; m_pcnt = 0;
      end else begin
         if (start) begin
            m_code = (upper > 4) ? 4 : upper;
            m_pol = amp_neg; m_settle = 0;
         end else if (eval_en && pend) begin
            if (m_settle == SETTLE - 1) begin
               m_settle = 0;
               if (hdr_low && m_code < 4) m_code++;
            end else m_settle++;
         end
         m_pcnt = pend ? 0 : m_pcnt + 1;
      end
      m_prev = eval_en;
   end

   // per-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (!done) begin
         int e1, e2;
         e1 = rst_n && (m_pcnt < PH_LEN);
         e2 = rst_n && (m_pcnt >= PH_LEN + 1) && (m_pcnt <= 2 * PH_LEN);
         check(ratio_code == m_code, "R7 code", ratio_code, m_code);
         check(pol_neg == m_pol, "R5 pol", pol_neg, m_pol);
         check(p1_pos == (e1 && !m_pol), "R2 p1_pos", p1_pos, e1 && !m_pol);
         check(p2_pos == (e2 && !m_pol), "R2 p2_pos", p2_pos, e2 && !m_pol);
         check(p1_neg == (e1 && m_pol), "R4 p1_neg", p1_neg, e1 && m_pol);
         check(p2_neg == (e2 && m_pol), "R4 p2_neg", p2_neg, e2 && m_pol);
         check(!(p1_pos && p2_pos) && !(p1_neg && p2_neg), "R3 overlap", 1, 0);
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   initial begin
      cyc(5);
      @(negedge clk);
      check(ratio_code == 3'd4 && !pol_neg, "R1 reset code/pol", ratio_code, 4);
      check({p1_pos, p2_pos, p1_neg, p2_neg} == 4'b0, "R1 reset phases", {p1_pos, p2_pos, p1_neg, p2_neg}, 0);
      rst_n = 1'b1;
      cyc(1);
      @(negedge clk);
      check(ratio_code == 3'd4, "R1 after reset", ratio_code, 4);
      cyc(130);
      // margin short: 2 -> 3 -> 4, then saturates
      amp_mag = 8'h40; amp_neg = 1'b0; hdr_low = 1'b1; eval_en = 1'b1;
      cyc(1);
      @(negedge clk);
      check(ratio_code == 3'd2, "R6 prediction 0x40", ratio_code, 2);
      cyc(1100);
      @(negedge clk);
      check(ratio_code == 3'd4, "R8 saturate", ratio_code, 4);
      // freeze: inputs wiggle with window closed
      eval_en = 1'b0;
      cyc(2);
      amp_mag = 8'h00; amp_neg = 1'b1; hdr_low = 1'b0;
      cyc(400);
      @(negedge clk);
      check(ratio_code == 3'd4 && !pol_neg, "R9 frozen", ratio_code, 4);
      // negative rail, illegal prediction clamps
      amp_mag = 8'hE0; amp_neg = 1'b1; hdr_low = 1'b0; eval_en = 1'b1;
      cyc(1);
      @(negedge clk);
      check(ratio_code == 3'd4, "R6 R8 clamp 7->4", ratio_code, 4);
      check(pol_neg == 1'b1, "R5 negative rail", pol_neg, 1);
      cyc(120);
      @(negedge clk);
      check(!p1_pos && !p2_pos, "R4 positive pair idle", p1_pos, 0);
      eval_en = 1'b0;
      cyc(3);
      // lowest prediction, short margin for one interval, then cleared
      amp_mag = 8'h1F; amp_neg = 1'b0; hdr_low = 1'b1; eval_en = 1'b1;
      cyc(1);
      @(negedge clk);
      check(ratio_code == 3'd0, "R6 prediction 0x1F", ratio_code, 0);
      cyc(PERIOD * SETTLE + 5);
      hdr_low = 1'b0;
      cyc(PERIOD * SETTLE * 3);
      @(negedge clk);
      check(ratio_code == 3'd1, "R10 hold when clear", ratio_code, 1);
      eval_en = 1'b0;
      cyc(20);
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule